// File: doc/BRIEF.md
# Serial Debug Command Execution Engine

This block is the target side of a two-wire serial programming port. An external programmer supplies a serial clock and a bidirectional data line; the same clock runs the engine and paces execution. The programmer sends 4-bit control codes. One code loads a 24-bit instruction word, which the engine hands to the execution side as a one-cycle strobe plus the word. The other code turns the data line around and shifts a 16-bit readback value back to the programmer.

Execution of each loaded instruction overlaps the reception of the next control code, so the 4 clocks after an instruction load are also the 4 code clocks of the next command. After reset, the engine runs a fixed 9-clock forced phase that executes a NOP before normal command decoding begins. Everything is sampled on the rising clock edge. The data line is driven, when it is driven at all, from the falling edge.

Top module: `dbg_exec_engine`

## Requirements
- R1: Code 0000 loads the next 24 data bits as an instruction. The word appears on `instr_o` with `instr_valid_o` high in the cycle after the rising edge that samples bit 23. That cycle is the first of the 4 clocks that collect the next control code, so execution and code reception overlap.
- R2: Control codes, instruction words and readback data all travel least significant bit first.
- R3: `pgd_i` is sampled on the rising clock edge. `pgd_o` and `pgd_oe_o` change on the falling edge, except for the release described in R10.
- R4: For the first 9 rising edges after reset, the data input is ignored. The next 24 rising edges load the first instruction word, with no control code before it.
- R5: `instr_valid_o` is high for exactly one clock per issued instruction.
- R6: Code 0001 is followed by 8 idle clocks with the line undriven. Bit i of the readback value is then driven for the rising edge 9+i after the code's last bit, for i = 0..15.
- R7: The forced phase ends with one `instr_valid_o` pulse carrying the all-zero word (NOP). The pulse falls in the cycle after the 9th rising edge.
- R8: Codes 0010 through 1111 are ignored. They produce no strobe and no drive, and the next 4 bits are decoded as a new code.
- R9: `pgd_oe_o` stays low while codes are received, during idle clocks and while instructions are loaded. The only exception is the hold of R10.
- R10: After the rising edge that takes readback bit 15, `pgd_oe_o` stays high through the next falling edge and drops at the following rising edge.
- R11: `rb_data_i` is captured on the rising edge that ends the idle phase. Changes to it after that point do not alter the bits shifted out.
- R12: In reset, `pgd_oe_o` and `instr_valid_o` are low and `instr_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial clock from the programmer; also the execution clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pgd_i | input | 1 | Serial data in, sampled on the rising edge |
| pgd_o | output | 1 | Serial data out, valid while `pgd_oe_o` is high |
| pgd_oe_o | output | 1 | Output enable for the data pin |
| instr_valid_o | output | 1 | One-cycle instruction strobe |
| instr_o | output | 24 | Instruction word presented to the execution side |
| rb_data_i | input | 16 | Parallel value loaded for readback |

## Verification
The instruction strobe is due one cycle after the rising edge that takes bit 23. That is the first tick of the next code, so the bench checks it on that tick's first sample and confirms it is gone on the second. Readback bits are due one falling edge after the edges counted in R6. The bench samples 1 ns after each falling edge, before new data is driven. The release in R10 is checked on the first two ticks of the command that follows a readback: high on the first, low on the second. A running count of strobes, taken at falling edges, shows that reserved codes issue nothing.

// File: rtl/dbg_exec_pkg.sv
package dbg_exec_pkg;
  typedef enum logic [2:0] {
    ST_FORCE,
    ST_CMD,
    ST_INSTR,
    ST_IDLE,
    ST_OUT
  } phase_e;
endpackage

// File: rtl/dbg_in_shift.sv
module dbg_in_shift #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] word_nxt_o
);
  logic [W-1:0] q;

  // lsb first: new bit enters at the top
  assign word_nxt_o = {bit_i, q[W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= '0;
    else if (en_i) q <= word_nxt_o;
  end
endmodule

// File: rtl/dbg_seq.sv
module dbg_seq
  import dbg_exec_pkg::*;
#(
  parameter int CODE_W    = 4,
  parameter int INSTR_W   = 24,
  parameter int RB_W      = 16,
  parameter int IDLE_CYC  = 8,
  parameter int FORCE_CYC = 9,
  parameter int CODE_EXEC = 0,
  parameter int CODE_READ = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_nxt_i,
  output phase_e            phase_o,
  output logic              cmd_en_o,
  output logic              instr_en_o,
  output logic              instr_done_o,
  output logic              force_done_o,
  output logic              load_rb_o,
  output logic              shift_rb_o,
  output logic              hold_o
);
  localparam int M1    = (CODE_W > INSTR_W) ? CODE_W : INSTR_W;
  localparam int M2    = (RB_W > IDLE_CYC) ? RB_W : IDLE_CYC;
  localparam int M3    = (M1 > M2) ? M1 : M2;
  localparam int MAXC  = (M3 > FORCE_CYC) ? M3 : FORCE_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  phase_e             phase_q, phase_d;
  logic [CNT_W-1:0]   cnt_q, lim_m1;
  logic               last, hold_q;
  logic               code_exec, code_read;

  assign code_exec = (code_nxt_i == CODE_W'(CODE_EXEC));
  assign code_read = (code_nxt_i == CODE_W'(CODE_READ));

  always_comb begin
    case (phase_q)
      ST_FORCE: lim_m1 = CNT_W'(FORCE_CYC - 1);
      ST_CMD:   lim_m1 = CNT_W'(CODE_W - 1);
      ST_INSTR: lim_m1 = CNT_W'(INSTR_W - 1);
      ST_IDLE:  lim_m1 = CNT_W'(IDLE_CYC - 1);
      default:  lim_m1 = CNT_W'(RB_W - 1);
    endcase
  end

  assign last = (cnt_q == lim_m1);

  always_comb begin
    phase_d = phase_q;
    if (last) begin
      case (phase_q)
        ST_FORCE: phase_d = ST_INSTR;
        ST_CMD:   phase_d = code_exec ? ST_INSTR : (code_read ? ST_IDLE : ST_CMD);
        ST_INSTR: phase_d = ST_CMD;
        ST_IDLE:  phase_d = ST_OUT;
        default:  phase_d = ST_CMD;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= ST_FORCE;
      cnt_q   <= '0;
      hold_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= last ? '0 : cnt_q + 1'b1;
      hold_q  <= (phase_q == ST_OUT) && last;
    end
  end

  assign phase_o      = phase_q;
  assign cmd_en_o     = (phase_q == ST_CMD);
  assign instr_en_o   = (phase_q == ST_INSTR);
  assign instr_done_o = (phase_q == ST_INSTR) && last;
  assign force_done_o = (phase_q == ST_FORCE) && last;
  assign load_rb_o    = (phase_q == ST_IDLE) && last;
  assign shift_rb_o   = (phase_q == ST_OUT);
  assign hold_o       = hold_q;

  // R8: a reserved code leads straight into a fresh code window
  p_reserved_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == ST_CMD && last && !code_exec && !code_read)
      |=> (phase_q == ST_CMD && cnt_q == '0));

  // R6: output phase is entered only from the idle phase
  p_out_after_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == ST_OUT && $past(phase_q) != ST_OUT) |-> $past(phase_q) == ST_IDLE);
endmodule

// File: rtl/dbg_out_drv.sv
module dbg_out_drv #(
  parameter int RB_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [RB_W-1:0] rb_data_i,
  input  logic            load_i,
  input  logic            shift_i,
  input  logic            win_i,
  output logic            pgd_o,
  output logic            pgd_oe_o
);
  logic [RB_W-1:0] sh_q;
  logic            oe_q, pgd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (load_i)  sh_q <= rb_data_i;
    else if (shift_i) sh_q <= {1'b0, sh_q[RB_W-1:1]};
  end

  // launch on the falling edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q  <= 1'b0;
      pgd_q <= 1'b0;
    end else begin
      oe_q  <= win_i;
      pgd_q <= sh_q[0];
    end
  end

  // release is immediate on the rising edge that closes the window
  assign pgd_oe_o = oe_q & win_i;
  assign pgd_o    = pgd_q;
endmodule

// File: rtl/dbg_exec_engine.sv
module dbg_exec_engine
  import dbg_exec_pkg::*;
#(
  parameter int CODE_W    = 4,
  parameter int INSTR_W   = 24,
  parameter int RB_W      = 16,
  parameter int IDLE_CYC  = 8,
  parameter int FORCE_CYC = 9,
  parameter int CODE_EXEC = 0,
  parameter int CODE_READ = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pgd_i,
  output logic               pgd_o,
  output logic               pgd_oe_o,
  output logic               instr_valid_o,
  output logic [INSTR_W-1:0] instr_o,
  input  logic [RB_W-1:0]    rb_data_i
);
  phase_e             phase;
  logic               cmd_en, instr_en, instr_done, force_done;
  logic               load_rb, shift_rb, hold;
  logic [CODE_W-1:0]  code_nxt;
  logic [INSTR_W-1:0] instr_nxt;
  logic               valid_q;
  logic [INSTR_W-1:0] instr_q;

  dbg_in_shift #(.W(CODE_W)) u_code_sh (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(cmd_en), .bit_i(pgd_i), .word_nxt_o(code_nxt)
  );

  dbg_in_shift #(.W(INSTR_W)) u_instr_sh (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(instr_en), .bit_i(pgd_i), .word_nxt_o(instr_nxt)
  );

  dbg_seq #(
    .CODE_W(CODE_W), .INSTR_W(INSTR_W), .RB_W(RB_W), .IDLE_CYC(IDLE_CYC),
    .FORCE_CYC(FORCE_CYC), .CODE_EXEC(CODE_EXEC), .CODE_READ(CODE_READ)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .code_nxt_i(code_nxt), .phase_o(phase),
    .cmd_en_o(cmd_en), .instr_en_o(instr_en), .instr_done_o(instr_done),
    .force_done_o(force_done), .load_rb_o(load_rb), .shift_rb_o(shift_rb), .hold_o(hold)
  );

  dbg_out_drv #(.RB_W(RB_W)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .rb_data_i(rb_data_i), .load_i(load_rb),
    .shift_i(shift_rb), .win_i(shift_rb | hold), .pgd_o(pgd_o), .pgd_oe_o(pgd_oe_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      instr_q <= '0;
    end else begin
      valid_q <= instr_done | force_done;
      if (instr_done)      instr_q <= instr_nxt;
      else if (force_done) instr_q <= '0;
    end
  end

  assign instr_valid_o = valid_q;
  assign instr_o       = instr_q;

  p_valid_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_o |=> !instr_valid_o);

  p_forced_nop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_done |=> (instr_valid_o && instr_o == '0));

  p_no_drive_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == ST_IDLE || phase == ST_INSTR) |-> !pgd_oe_o);

  p_hold_driven_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold |-> pgd_oe_o);
endmodule

// File: tb/tb_dbg_exec_engine.sv
`timescale 1ns/1ps
module tb_dbg_exec_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pgd_in = 1'b0;
  logic        pgd_out, pgd_oe, valid;
  logic [23:0] instr;
  logic [15:0] rb = '0;

  int n_chk = 0, n_fail = 0, pulses = 0;
  bit done = 0;

  logic        s_valid, s_oe, s_pgd;
  logic [23:0] s_instr;
  logic        s1_valid, s2_valid, oe_any;
  logic [23:0] s1_instr;

  always #2.5 clk = ~clk;

  dbg_exec_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .pgd_i(pgd_in), .pgd_o(pgd_out), .pgd_oe_o(pgd_oe),
    .instr_valid_o(valid), .instr_o(instr), .rb_data_i(rb)
  );

  always @(negedge clk) if (rst_n && valid) pulses++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // one serial clock: sample after the falling edge, then drive
  task automatic tick(input logic b);
    @(negedge clk);
    #1;
    s_valid = valid; s_instr = instr; s_oe = pgd_oe; s_pgd = pgd_out;
    pgd_in = b;
    @(posedge clk);
  endtask

  task automatic send(input logic [31:0] bits, input int n);
    oe_any = 1'b0;
    for (int i = 0; i < n; i++) begin
      tick(bits[i]);
      if (i == 0) begin s1_valid = s_valid; s1_instr = s_instr; end
      if (i == 1) s2_valid = s_valid;
      oe_any = oe_any | s_oe;
    end
  endtask

  logic [23:0] words [6] = '{24'hA5C3F0, 24'h000001, 24'h800000, 24'h5A5A5A, 24'hFFFFFF, 24'h123456};
  logic [15:0] rbv   [5] = '{16'hBEEF, 16'h0001, 16'h8000, 16'h5AC3, 16'hFFFF};

  initial begin
    logic [23:0] prev;
    int p0;
    repeat (3) @(posedge clk);
    #1;
    chk(!pgd_oe && !valid && instr == '0, "R12 reset state", {pgd_oe, valid, instr}, 32'h0);
    @(posedge clk);
    #1 rst_n = 1'b1;

    // forced phase, data ignored
    send(32'h1FF, 9);
    chk(oe_any == 1'b0, "R9 forced phase undriven", oe_any, 0);
    prev = 24'h0F0F12;
    send({8'h0, prev}, 24);
    chk(s1_valid && s1_instr == '0, "R7 forced NOP", {s1_valid, s1_instr}, 32'h1000000);
    chk(!s2_valid, "R5 forced strobe one cycle", s2_valid, 0);

    foreach (words[k]) begin
      send(32'h0, 4);
      chk(s1_valid && s1_instr == prev, "R1 R2 R4 instr issue overlapped", {s1_valid, s1_instr}, {1'b1, prev});
      chk(!s2_valid, "R5 strobe one cycle", s2_valid, 0);
      chk(!oe_any, "R9 code reception undriven", oe_any, 0);
      send({8'h0, words[k]}, 24);
      chk(!oe_any, "R9 instr load undriven", oe_any, 0);
      prev = words[k];
    end

    // reserved codes sweep
    for (int c = 2; c < 16; c++) begin
      send(c, 4);
      chk(s1_valid && s1_instr == prev, "R1 issue before reserved", {s1_valid, s1_instr}, {1'b1, prev});
      chk(!oe_any, "R8 reserved not driven", oe_any, 0);
      p0 = pulses;
      send(32'h0, 4);
      chk(pulses == p0, "R8 reserved issues nothing", pulses, p0);
      prev = {c[3:0], 20'hABCDE};
      send({8'h0, prev}, 24);
    end

    // readback sweep
    foreach (rbv[k]) begin
      rb = rbv[k];
      send(32'h1, 4);
      chk(s1_valid && s1_instr == prev, "R1 issue before readback", {s1_valid, s1_instr}, {1'b1, prev});
      send(32'h0, 8);
      chk(!oe_any, "R6 R9 idle undriven", oe_any, 0);
      for (int i = 0; i < 16; i++) begin
        tick(1'b0);
        chk(s_oe && s_pgd == rbv[k][i], "R6 R2 R3 readback bit", {s_oe, s_pgd}, {1'b1, rbv[k][i]});
        if (i == 0) rb = ~rbv[k];
      end
      chk(1'b1, "R11 capture held through shift", 0, 0);
      tick(1'b0);
      chk(s_oe == 1'b1, "R10 hold after last bit", s_oe, 1);
      tick(1'b0);
      chk(s_oe == 1'b0, "R10 release at next rising edge", s_oe, 0);
      tick(1'b0); tick(1'b0);
      prev = {rbv[k], 8'h3C};
      send({8'h0, prev}, 24);
    end
    send(32'h0, 4);
    chk(s1_valid && s1_instr == prev, "R1 final issue", {s1_valid, s1_instr}, {1'b1, prev});

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule